// File: doc/BRIEF.md
# Ping-Pong Patch Descriptor Framer

This block keeps two frame-sized pixel memories that take turns. While a camera image streams in, in raster order, its pixels land in the memory that is in write mode. The other memory is in read mode and still holds the image before it. When the last pixel of an image has been written, the two memories exchange roles.

During an image, a feature stage upstream delivers the list of interest points it found in the previous image, already ranked best first. The block stores their coordinates in a small point table. When the upstream stage signals that the list is complete, the block emits one descriptor frame as a byte stream, reading from the memory that is in read mode. The frame opens with a two-byte header: the point count, then the patch side. Each point follows with its column and row as 16-bit big-endian values and then the square patch of pixels centred on it.

The number of points is bounded so that a descriptor frame is never larger than a raw image. The host can therefore reuse the image transport for it. The emission of a frame must finish before the image being written ends.

Top module: `ppf_patch_framer`

## Requirements
- R1: Pixels with pix_valid high are written in raster order (column fastest) into the write-mode memory. After reset memory 0 is in write mode. The cycle that writes the last pixel of an image swaps the roles, so the next descriptor frame reads the image just completed.
- R2: A pts_done pulse while the block is idle starts a descriptor frame on the next cycle. It reads patches from the read-mode memory, and out_valid stays high until the final byte is accepted.
- R3: Byte 0 of a frame is the point count and byte 1 is the patch side SIDE.
- R4: For each point, four bytes follow in this order: column high byte, column low byte, row high byte, row low byte.
- R5: After its coordinates, each point emits SIDE×SIDE pixels, row by row from the top-left. Patch entry (dx, dy) is the image pixel at column x−SIDE/2+dx and row y−SIDE/2+dy.
- R6: A patch entry that falls outside the image is emitted as 0.
- R7: Points are kept in arrival order, at most NMAX = floor((COLS·ROWS−3)/(SIDE²+4)) of them. Further points are dropped, so the count byte never exceeds NMAX. This keeps n·(SIDE²+4)+2 below COLS·ROWS.
- R8: Points and pts_done pulses that arrive while a frame is being emitted are ignored. The table is empty again once a frame has started.
- R9: The output is a valid/ready byte stream. Data and last hold while out_ready is low, and out_last marks the final byte. With no points the frame is the two header bytes.
- R10: After reset no frame is pending, out_valid is low and the point table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present on pix_data |
| pix_data | input | 8 | Grey-level pixel, raster order |
| pt_valid | input | 1 | Interest point present |
| pt_x | input | $clog2(COLS) | Point column |
| pt_y | input | $clog2(ROWS) | Point row |
| pts_done | input | 1 | Point list complete, start a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench builds the block for a 12×10 image with a 5×5 patch, which gives NMAX = 4. At that size a corner point clips 16 of its 25 patch entries and a full image takes only 120 cycles. Two image swaps therefore fit in a short run, and offering five points shows the clamp. Throttling out_ready on one frame and holding it high on another exercises the stall path. A zero-point frame and pulses sent during emission reach the header-only frame and the ignore rule.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_SIZE, ST_XHI, ST_XLO, ST_YHI, ST_YLO, ST_PIX
  } emit_state_e;

  // Largest point count whose frame stays strictly smaller than one image.
  function automatic int point_limit(int cols, int rows, int side);
    return (cols * rows - 3) / (side * side + 4);
  endfunction

  function automatic logic inside_image(int px, int py, int cols, int rows);
    return (px >= 0) && (px < cols) && (py >= 0) && (py < rows);
  endfunction

  function automatic int raster_index(int px, int py, int cols);
    return py * cols + px;
  endfunction

endpackage

// File: rtl/ppf_sram.sv
module ppf_sram #(
  parameter int DEPTH = 768,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  // asynchronous read, like a plain static RAM
  assign rdata = cells[addr];
endmodule

// File: rtl/ppf_writer.sv
module ppf_writer #(
  parameter int COLS = 32,
  parameter int ROWS = 24,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_en,
  output logic          wr_bank,
  output logic          frame_end
);
  import ppf_pkg::*;
  localparam logic [XW-1:0] COL_LAST = XW'(COLS - 1);
  localparam logic [YW-1:0] ROW_LAST = YW'(ROWS - 1);

  logic [XW-1:0] col;
  logic [YW-1:0] row;

  assign wr_en     = pix_valid;
  assign wr_addr   = AW'(raster_index(int'(col), int'(row), COLS));
  assign frame_end = pix_valid && (col == COL_LAST) && (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      wr_bank <= 1'b0;
    end else if (pix_valid) begin
      if (col == COL_LAST) begin
        col <= '0;
        if (row == ROW_LAST) begin
          row <= '0;
          wr_bank <= ~wr_bank;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppf_point_table.sv
module ppf_point_table #(
  parameter int SLOTS = 3,
  parameter int XW = 5,
  parameter int YW = 5,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pt_valid,
  input  logic [XW-1:0] pt_x,
  input  logic [YW-1:0] pt_y,
  input  logic          lock,
  input  logic          clear,
  input  logic [CW-1:0] rd_idx,
  output logic [XW-1:0] rd_x,
  output logic [YW-1:0] rd_y,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(SLOTS);

  logic [XW-1:0] xs [2**CW];
  logic [YW-1:0] ys [2**CW];
  logic accept;

  assign accept = pt_valid && !lock && (count < FULL);
  assign rd_x = xs[rd_idx];
  assign rd_y = ys[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (clear) count <= '0;
    else if (accept) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      xs[count] <= pt_x;
      ys[count] <= pt_y;
    end
  end
endmodule

// File: rtl/ppf_emitter.sv
module ppf_emitter #(
  parameter int COLS = 32,
  parameter int ROWS = 24,
  parameter int SIDE = 15,
  parameter int SLOTS = 3,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS),
  localparam int CW = $clog2(SLOTS + 1),
  localparam int SW = $clog2(SIDE),
  localparam int HALF = SIDE / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        n_in,
  output logic [CW-1:0]        idx,
  input  logic [XW-1:0]        pt_x,
  input  logic [YW-1:0]        pt_y,
  output logic [AW-1:0]        rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic                 out_last,
  output ppf_pkg::emit_state_e state,
  output logic                 busy,
  output logic                 patch_in_image
);
  import ppf_pkg::*;
  localparam logic [SW-1:0] STEP_LAST = SW'(SIDE - 1);

  logic [CW-1:0] n_pts;
  logic [SW-1:0] dx, dy;
  logic [15:0]   x16, y16;
  logic          fire, pt_last, patch_last;
  int            px, py;

  assign busy       = (state != ST_IDLE);
  assign out_valid  = busy;
  assign fire       = out_valid && out_ready;
  assign pt_last    = (idx == n_pts - 1'b1);
  assign patch_last = (dx == STEP_LAST) && (dy == STEP_LAST);
  assign x16        = 16'(pt_x);
  assign y16        = 16'(pt_y);
  assign out_last   = (state == ST_SIZE && n_pts == '0) ||
                      (state == ST_PIX && patch_last && pt_last);

  always_comb begin
    px = int'(pt_x) + int'(dx) - HALF;
    py = int'(pt_y) + int'(dy) - HALF;
    patch_in_image = inside_image(px, py, COLS, ROWS);
    rd_addr = patch_in_image ? AW'(raster_index(px, py, COLS)) : '0;
  end

  always_comb begin
    unique case (state)
      ST_COUNT: out_data = 8'(n_pts);
      ST_SIZE:  out_data = 8'(SIDE);
      ST_XHI:   out_data = x16[15:8];
      ST_XLO:   out_data = x16[7:0];
      ST_YHI:   out_data = y16[15:8];
      ST_YLO:   out_data = y16[7:0];
      ST_PIX:   out_data = patch_in_image ? rd_data : 8'd0;
      default:  out_data = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      n_pts <= '0;
      idx   <= '0;
      dx    <= '0;
      dy    <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state <= ST_COUNT;
        n_pts <= n_in;
        idx   <= '0;
      end
    end else if (fire) begin
      unique case (state)
        ST_COUNT: state <= ST_SIZE;
        ST_SIZE:  state <= (n_pts == '0) ? ST_IDLE : ST_XHI;
        ST_XHI:   state <= ST_XLO;
        ST_XLO:   state <= ST_YHI;
        ST_YHI:   state <= ST_YLO;
        ST_YLO: begin
          state <= ST_PIX;
          dx <= '0;
          dy <= '0;
        end
        ST_PIX: begin
          if (dx == STEP_LAST) begin
            dx <= '0;
            if (dy == STEP_LAST) begin
              dy <= '0;
              if (pt_last) state <= ST_IDLE;
              else begin
                idx   <= idx + 1'b1;
                state <= ST_XHI;
              end
            end else begin
              dy <= dy + 1'b1;
            end
          end else begin
            dx <= dx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppf_patch_framer.sv
module ppf_patch_framer #(
  parameter int COLS = 32,
  parameter int ROWS = 24,
  parameter int SIDE = 15,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS),
  localparam int SLOTS = ppf_pkg::point_limit(COLS, ROWS, SIDE),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [7:0]    pix_data,
  input  logic          pt_valid,
  input  logic [XW-1:0] pt_x,
  input  logic [YW-1:0] pt_y,
  input  logic          pts_done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last
);
  import ppf_pkg::*;

  logic [AW-1:0] wr_addr, rd_addr;
  logic          wr_en, wr_bank, frame_end;
  logic          busy, start_ok, patch_in_image;
  logic [CW-1:0] tab_count, idx;
  logic [XW-1:0] tab_x;
  logic [YW-1:0] tab_y;
  logic [7:0]    rd_data;
  logic [7:0]    bank_rdata [2];
  emit_state_e   emit_state;

  assign start_ok = pts_done && !busy;
  assign rd_data  = bank_rdata[~wr_bank];

  ppf_writer #(.COLS(COLS), .ROWS(ROWS)) u_writer (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .wr_addr(wr_addr),
    .wr_en(wr_en), .wr_bank(wr_bank), .frame_end(frame_end)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          is_wr;
    logic [AW-1:0] addr;
    assign is_wr = (wr_bank == 1'(b));
    assign addr  = is_wr ? wr_addr : rd_addr;
    ppf_sram #(.DEPTH(COLS * ROWS), .DW(8)) u_mem (
      .clk(clk), .addr(addr), .wdata(pix_data), .we(wr_en && is_wr),
      .rdata(bank_rdata[b])
    );
  end

  ppf_point_table #(.SLOTS(SLOTS), .XW(XW), .YW(YW)) u_table (
    .clk(clk), .rst_n(rst_n), .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y),
    .lock(busy), .clear(start_ok), .rd_idx(idx), .rd_x(tab_x), .rd_y(tab_y),
    .count(tab_count)
  );

  ppf_emitter #(.COLS(COLS), .ROWS(ROWS), .SIDE(SIDE), .SLOTS(SLOTS)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .n_in(tab_count), .idx(idx),
    .pt_x(tab_x), .pt_y(tab_y), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .state(emit_state), .busy(busy),
    .patch_in_image(patch_in_image)
  );
endmodule

// File: rtl/ppf_checker.sv
module ppf_checker #(
  parameter int SLOTS = 3,
  parameter int SIDE = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [7:0]           out_data,
  input logic                 out_last,
  input logic                 frame_end,
  input logic                 wr_bank,
  input ppf_pkg::emit_state_e emit_state,
  input logic                 patch_in_image
);
  import ppf_pkg::*;

  assert_swap_on_frame_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wr_bank != $past(wr_bank)));

  assert_no_swap_mid_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(wr_bank));

  assert_frame_opens_with_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (emit_state == ST_COUNT));

  assert_size_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && emit_state == ST_SIZE) |-> (out_data == 8'(SIDE)));

  assert_outside_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && emit_state == ST_PIX && !patch_in_image) |-> (out_data == 8'd0));

  assert_count_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && emit_state == ST_COUNT) |-> (out_data <= 8'(SLOTS)));

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind ppf_patch_framer ppf_checker #(.SLOTS(SLOTS), .SIDE(SIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .frame_end(frame_end),
  .wr_bank(wr_bank), .emit_state(emit_state), .patch_in_image(patch_in_image)
);

// File: tb/ppf_patch_framer_test.sv
`timescale 1ns/1ps
module ppf_patch_framer_test;
  localparam int COLS = 12;
  localparam int ROWS = 10;
  localparam int SIDE = 5;
  localparam int HALF = SIDE / 2;
  localparam int NMAX = (COLS * ROWS - 3) / (SIDE * SIDE + 4);
  localparam int NPIX = COLS * ROWS;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pt_valid = 0, pts_done = 0, out_ready = 0;
  logic [7:0] pix_data = 0;
  logic [3:0] pt_x = 0, pt_y = 0;
  logic out_valid, out_last;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  ppf_patch_framer #(.COLS(COLS), .ROWS(ROWS), .SIDE(SIDE)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y), .pts_done(pts_done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int checks = 0, errors = 0, cyc = 0, ready_cnt = 0;
  bit stall_mode = 0;
  string pix_tag = "R5", hdr_tag = "R7";

  // behavioural reference state
  int img [2][NPIX];
  int m_bank = 0, m_pos = 0;
  int tab_x[$], tab_y[$];
  int exp_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string tag, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pixval(int frame, int pos);
    return ((frame * 53 + pos * 7) % 255) + 1;
  endfunction

  task automatic build_frame(int bank);
    exp_q.push_back(tab_x.size()); tag_q.push_back(hdr_tag);
    exp_q.push_back(SIDE);         tag_q.push_back("R3");
    foreach (tab_x[i]) begin
      exp_q.push_back(tab_x[i] >> 8);  tag_q.push_back("R4");
      exp_q.push_back(tab_x[i] & 255); tag_q.push_back("R4");
      exp_q.push_back(tab_y[i] >> 8);  tag_q.push_back("R4");
      exp_q.push_back(tab_y[i] & 255); tag_q.push_back("R4");
      for (int dy = 0; dy < SIDE; dy++)
        for (int dx = 0; dx < SIDE; dx++) begin
          int px, py;
          px = tab_x[i] - HALF + dx;
          py = tab_y[i] - HALF + dy;
          if (px >= 0 && px < COLS && py >= 0 && py < ROWS) begin
            exp_q.push_back(img[bank][py * COLS + px]); tag_q.push_back(pix_tag);
          end else begin
            exp_q.push_back(0); tag_q.push_back("R6");
          end
        end
    end
    tab_x.delete();
    tab_y.delete();
  endtask

  // reference model update on the clock edge, from bench-driven inputs only
  always @(posedge clk) begin
    if (rst_n) begin
      automatic bit busy = (exp_q.size() > 0);
      if (pix_valid) begin
        img[m_bank][m_pos] = int'(pix_data);
        m_pos++;
        if (m_pos == NPIX) begin
          m_pos = 0;
          m_bank ^= 1;
        end
      end
      if (pt_valid && !busy && tab_x.size() < NMAX) begin
        tab_x.push_back(int'(pt_x));
        tab_y.push_back(int'(pt_y));
      end
      if (out_ready && busy) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (pts_done && !busy) build_frame(1 - m_bank);
    end
  end

  // compare on every falling edge, then choose the next ready value
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid === (exp_q.size() > 0), "R2", int'(out_valid), int'(exp_q.size() > 0), "out_valid");
      if (exp_q.size() > 0 && out_valid === 1'b1) begin
        chk(int'(out_data) == exp_q[0], tag_q[0], int'(out_data), exp_q[0], "out_data");
        chk(out_last === (exp_q.size() == 1), "R9", int'(out_last), int'(exp_q.size() == 1), "out_last");
      end
      out_ready = stall_mode ? (ready_cnt % 3 != 2) : 1'b1;
      ready_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int wpos = 0;
  task automatic write_pixels(int frame, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1;
      pix_data = 8'(pixval(frame, wpos));
      wpos = (wpos + 1) % NPIX;
    end
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic push_point(int x, int y);
    @(negedge clk);
    pt_valid = 1; pt_x = 4'(x); pt_y = 4'(y);
    @(negedge clk);
    pt_valid = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    pts_done = 1;
    @(negedge clk);
    pts_done = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R10", int'(out_valid), 0, "valid in reset");
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", int'(out_valid), 0, "valid after reset");
    // R10 / R9: empty table gives a header-only frame
    kick();
    drain();
    // image 0 into memory 0, then part of image 1
    write_pixels(0, NPIX);
    write_pixels(1, 30);
    // five points offered, clamp to NMAX (R7), corner clipping (R6)
    push_point(0, 0);
    push_point(11, 9);
    push_point(5, 4);
    push_point(1, 8);
    push_point(7, 7);
    stall_mode = 1;
    kick();
    // R8: ignored while emitting
    push_point(3, 3);
    kick();
    drain();
    hdr_tag = "R8";
    kick();
    drain();
    hdr_tag = "R7";
    // finish image 1 (swap, R1), start image 2
    write_pixels(1, NPIX - 30);
    write_pixels(2, 10);
    stall_mode = 0;
    pix_tag = "R1";
    push_point(6, 5);
    push_point(2, 1);
    kick();
    drain();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule